// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address order for a single read or write burst on a double-data-rate SDRAM interface. Two data words move on every clock, so each active cycle gives one pair: the column for the even burst position and the column for the odd one. A configuration load sets the burst length and the ordering. A start pulse gives the first column. The block then steps through the burst two positions per cycle. It flags the final pair, and it stops early when a terminate request arrives.

Within an aligned block of BL columns, sequential ordering wraps the low log2(BL) bits by addition. Interleaved ordering XORs them with the burst position. The column bits above that block stay equal to the start column for the whole burst. The controller has two states. In ST_IDLE it waits; a start pulse takes it to ST_RUN (transition "launch"). ST_RUN stays in ST_RUN while pairs remain (transition "advance"). It returns to ST_IDLE on the final pair or on a terminate request (transition "finish").

Top module: `burst_colseq`

## Requirements
- R1: While reset is asserted, and afterwards until the first start, pair_valid and last_pair are low. Reset selects length code 2 (BL 4) with sequential order.
- R2: A start pulse seen in ST_IDLE makes pair_valid rise on the next cycle. The burst then shows BL/2 consecutive pairs, and last_pair is high only on the final pair when no terminate request arrives.
- R3: In sequential order, the pair at positions p and p+1 (p even) carries ((S + p) mod BL) and ((S + p + 1) mod BL) in its low log2(BL) bits, where S is the start column.
- R4: In interleaved order, the low log2(BL) bits are S XOR p and S XOR (p+1). For BL 4 with start 1 the order is 1,0,3,2. For BL 8 with start 5 it is 5,4,7,6,1,0,3,2.
- R5: Column bits above log2(BL) equal those of the start column on both lanes for the whole burst.
- R6: cfg_len_code values 1, 2, 3 and 4 select BL 2, 4, 8 and 16. cfg_interleave 1 selects interleaved order and 0 selects sequential.
- R7: A load with a reserved length code (0, 5, 6 or 7) is rejected in full, and the last accepted length and order remain in force.
- R8: When stop is high during an active pair, that pair is the last one: last_pair is high in that same cycle, and pair_valid is low on the next cycle.
- R9: A start pulse during a burst is ignored. It neither restarts nor extends the burst.
- R10: The length, order and start column are captured at the start pulse. A load during a burst, or in the same cycle as the start, affects only later bursts.
- R11: stop while idle has no effect, and pair_valid stays low without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Load burst length code and order |
| cfg_len_code | input | 3 | Burst length code (1..4 valid) |
| cfg_interleave | input | 1 | 1 interleaved, 0 sequential |
| start | input | 1 | Begin a burst (ignored while busy) |
| start_col | input | 9 | First column of the burst |
| stop | input | 1 | Terminate the running burst after the current pair |
| pair_valid | output | 1 | A column pair is presented this cycle |
| last_pair | output | 1 | Current pair is the final one |
| col_even | output | 9 | Column for the even burst position |
| col_odd | output | 9 | Column for the odd burst position |

## Verification
A wrong burst position or a wrongly captured start column shows up in the same cycle as a bad column on col_even or col_odd. A wrong length or a lost state change shows up as a misplaced last_pair, or as pair_valid ending too early or too late, within one burst of the fault. A rejected or wrongly accepted configuration load is only seen at the next start. For that reason each load is followed by a full burst that the per-cycle reference model checks pair by pair.

// File: rtl/burst_colseq_pkg.sv
package burst_colseq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    // A length code is usable when it lies in 1..max_log
    function automatic logic len_code_ok(input logic [2:0] code, input int max_log);
        return (int'(code) >= 1) && (int'(code) <= max_log);
    endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
    import burst_colseq_pkg::*;
#(
    parameter int MAX_LOG = 4,
    parameter int LOG_W   = 3,
    parameter int RST_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LOG_W-1:0] code,
    input  logic             il_in,
    output logic [LOG_W-1:0] len_log,
    output logic             il
);

    logic accept;

    always_comb begin
        accept = load && len_code_ok(3'(code), MAX_LOG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_log <= LOG_W'(RST_LOG);
            il      <= 1'b0;
        end else if (accept) begin
            len_log <= code;
            il      <= il_in;
        end
    end

endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_colseq_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4,
    parameter int LOG_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    input  logic [COL_W-1:0]   start_col,
    input  logic [LOG_W-1:0]   cfg_log,
    input  logic               cfg_il,
    output logic               run,
    output logic               last,
    output logic [MAX_LOG-1:0] pos,
    output logic [COL_W-1:0]   base,
    output logic [LOG_W-1:0]   blog,
    output logic               bil
);

    localparam int CNT_W = MAX_LOG + 1;

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] pos_ext;
    logic [CNT_W-1:0] burst_len;
    logic             at_end;

    always_comb begin
        pos_ext   = {1'b0, pos};
        burst_len = CNT_W'(1) << blog;
        at_end    = (pos_ext + CNT_W'(2)) == burst_len;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (at_end || stop) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
            base  <= '0;
            blog  <= '0;
            bil   <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pos  <= '0;
                        base <= start_col;
                        blog <= cfg_log;
                        bil  <= cfg_il;
                    end
                end
                ST_RUN:  pos <= pos + MAX_LOG'(2);
                default: pos <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        run  = 1'b0;
        last = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                run  = 1'b1;
                last = at_end || stop;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/burst_idx_gen.sv
module burst_idx_gen #(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4,
    parameter int LOG_W   = 3
) (
    input  logic [COL_W-1:0]   base,
    input  logic [MAX_LOG-1:0] pos,
    input  logic [LOG_W-1:0]   blog,
    input  logic               il,
    output logic [COL_W-1:0]   col
);

    logic [COL_W-1:0] mask, posx, low;

    always_comb begin
        mask = (COL_W'(1) << blog) - COL_W'(1);
        posx = COL_W'(pos);
        low  = il ? (base ^ posx) : (base + posx);
        col  = (base & ~mask) | (low & mask);
    end

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
    import burst_colseq_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [2:0]       cfg_len_code,
    input  logic             cfg_interleave,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             stop,
    output logic             pair_valid,
    output logic             last_pair,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd
);

    localparam int LOG_W = 3;
    localparam int LANES = 2;

    logic [LOG_W-1:0]   cfg_log, blog;
    logic               cfg_il, bil;
    logic [MAX_LOG-1:0] pos;
    logic [COL_W-1:0]   base;
    logic [COL_W-1:0]   lane_col [LANES];

    burst_cfg_reg #(.MAX_LOG(MAX_LOG), .LOG_W(LOG_W), .RST_LOG(2)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .code    (cfg_len_code),
        .il_in   (cfg_interleave),
        .len_log (cfg_log),
        .il      (cfg_il)
    );

    burst_fsm #(.COL_W(COL_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg_log   (cfg_log),
        .cfg_il    (cfg_il),
        .run       (pair_valid),
        .last      (last_pair),
        .pos       (pos),
        .base      (base),
        .blog      (blog),
        .bil       (bil)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [MAX_LOG-1:0] lane_pos;
        assign lane_pos = pos | MAX_LOG'(g);
        burst_idx_gen #(.COL_W(COL_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W)) u_idx (
            .base (base),
            .pos  (lane_pos),
            .blog (blog),
            .il   (bil),
            .col  (lane_col[g])
        );
    end

    assign col_even = lane_col[0];
    assign col_odd  = lane_col[1];

endmodule

// File: rtl/burst_colseq_chk.sv
module burst_colseq_chk #(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             pair_valid,
    input logic             last_pair,
    input logic [COL_W-1:0] col_even,
    input logic [COL_W-1:0] col_odd
);

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_valid && start) |=> pair_valid);

    assert_burst_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !last_pair) |=> pair_valid);

    assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_pair |-> pair_valid);

    assert_last_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_pair |=> !pair_valid);

    assert_lane_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (col_even[0] != col_odd[0]));

    assert_upper_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ((col_even >> MAX_LOG) == (col_odd >> MAX_LOG)));

    assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !last_pair) |=> $stable(col_even >> MAX_LOG));

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_valid && !start) |=> !pair_valid);

endmodule

bind burst_colseq burst_colseq_chk #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pair_valid (pair_valid),
    .last_pair  (last_pair),
    .col_even   (col_even),
    .col_odd    (col_odd)
);

// File: tb/burst_colseq_test.sv
module burst_colseq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_len_code = 3'd0;
    logic       cfg_interleave = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = 9'd0;
    logic       stop = 1'b0;
    logic       pair_valid, last_pair;
    logic [8:0] col_even, col_odd;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R1";

    // reference model state
    int  m_run = 0, m_pos = 0, m_base = 0, m_log = 0, m_il = 0;
    int  c_log = 2, c_il = 0;

    always #4 clk = ~clk;

    burst_colseq uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_len_code(cfg_len_code),
        .cfg_interleave(cfg_interleave), .start(start), .start_col(start_col), .stop(stop),
        .pair_valid(pair_valid), .last_pair(last_pair), .col_even(col_even), .col_odd(col_odd)
    );

    function automatic int ref_col(int base, int p, int lg, int il);
        int bl = 1 << lg;
        int lo = il != 0 ? ((base % bl) ^ p) : ((base + p) % bl);
        return (base - (base % bl)) + lo;
    endfunction

    always @(negedge clk) begin
        int ev, od, lst;
        if (!rst_n) begin
            m_run = 0; c_log = 2; c_il = 0;
            n_checks++;
            if (pair_valid !== 1'b0 || last_pair !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 in reset: valid=%0b last=%0b expected 0 0", pair_valid, last_pair);
            end
        end else begin
            ev  = m_run != 0 ? ref_col(m_base, m_pos, m_log, m_il) : 0;
            od  = m_run != 0 ? ref_col(m_base, m_pos + 1, m_log, m_il) : 0;
            lst = (m_run != 0) && ((m_pos + 2 == (1 << m_log)) || stop);
            n_checks++;
            if (pair_valid !== (m_run != 0) || last_pair !== (lst != 0) ||
                (m_run != 0 && (int'(col_even) != ev || int'(col_odd) != od))) begin
                n_fail++;
                $display("FAIL %s: valid=%0b last=%0b even=%0d odd=%0d expected valid=%0b last=%0b even=%0d odd=%0d",
                         tag, pair_valid, last_pair, col_even, col_odd, m_run != 0, lst != 0, ev, od);
            end
            // model advance for the coming edge
            if (m_run == 0) begin
                if (start) begin
                    m_run = 1; m_pos = 0; m_base = int'(start_col); m_log = c_log; m_il = c_il;
                end
            end else if (lst != 0) begin
                m_run = 0;
            end else begin
                m_pos += 2;
            end
            if (cfg_load && cfg_len_code >= 3'd1 && cfg_len_code <= 3'd4) begin
                c_log = int'(cfg_len_code); c_il = int'(cfg_interleave);
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic load(int code, int il);
        cfg_load = 1'b1; cfg_len_code = 3'(code); cfg_interleave = il[0];
        step();
        cfg_load = 1'b0;
    endtask

    task automatic burst(int col, int wait_n = 10);
        start = 1'b1; start_col = 9'(col);
        step();
        start = 1'b0;
        step(wait_n);
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        tag = "R2"; burst(9'h0A5);                 // default BL4 sequential (R6 reset value)
        tag = "R6"; load(1, 0); burst(9'h013);
        tag = "R3"; load(3, 0); burst(9'h1F5);
        load(4, 0); burst(9'h13B);
        tag = "R4"; load(2, 1); burst(1, 4); burst(2, 4); burst(3, 4);
        load(3, 1); burst(4); burst(5);
        tag = "R5"; load(4, 1); burst(9'h1A9);
        tag = "R7"; load(0, 0); load(7, 0); load(5, 0); burst(9'h0C6);
        tag = "R8";
        start = 1'b1; start_col = 9'h052; step(); start = 1'b0;
        step(2); stop = 1'b1; step(); stop = 1'b0; step(10);
        tag = "R9"; load(3, 0);
        start = 1'b1; start_col = 9'h07E; step(); start_col = 9'h011; step(3);
        start = 1'b0; step(8);
        tag = "R10"; load(2, 1);
        start = 1'b1; start_col = 9'h10D; cfg_load = 1'b1; cfg_len_code = 3'd4; cfg_interleave = 1'b0;
        step(); start = 1'b0; cfg_load = 1'b0; step();
        load(1, 1); step(6); burst(9'h0F3);
        tag = "R11"; stop = 1'b1; step(3); stop = 1'b0; step(2);
        burst(9'h101);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule